// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block is the machine-mode timer of a small multi-hart system. It keeps one free-running 64-bit time counter and one 64-bit compare value per hart. Software reaches all of them through a plain 32-bit register bus, so each 64-bit register is accessed as two 32-bit words. The block decodes offsets within a 32 KiB window whose base address the platform chooses. The base must be at least 4-byte aligned.

Each hart owns one timer-interrupt output. That output is high whenever the counter, compared as an unsigned number, has reached or passed that hart's compare value. The counter advances by one on every cycle in which the tick-enable input is high. A system can therefore run the time base from a slower reference by pulsing tick enable.

The compare slots start at offset 0x0000 and are 8 bytes apart. The counter sits at the top of the window, at offset 0x7FF8. The window has room for at most 4095 compare slots. The number of harts is a parameter.

Top module: `mtimer_unit`

## Requirements
- R1: Reset sets the counter to zero, sets every compare value to all ones and sets the read data to zero. All interrupt outputs are low after reset.
- R2: The counter rises by exactly one at each clock edge where `tick_en` is high. It holds its value otherwise.
- R3: Reads and writes to offset 0x7FF8 reach counter bits 31:0. Reads and writes to offset 0x7FFC reach counter bits 63:32.
- R4: Reads and writes to offset n*8 reach bits 31:0 of hart n's compare value. Reads and writes to offset n*8+4 reach bits 63:32 of that value.
- R5: On a write, `bus_be[i]` high lets `bus_wdata[8i+7:8i]` replace that byte of the addressed word. Bytes whose strobe is low keep their value.
- R6: A write to either counter word wins over the tick in that cycle. The written bytes take the written value, and the rest of the counter keeps its pre-write value without incrementing.
- R7: `timer_irq[n]` is high exactly when the counter, compared unsigned, is greater than or equal to hart n's compare value. The output follows register updates in the same cycle that the updated registers are first visible.
- R8: `bus_rdata` carries the value at the requested offset one clock after a read request (`bus_req` high, `bus_we` low). After any other cycle it is zero.
- R9: Offsets for compare slots of harts numbered NUM_HARTS or higher read as zero, and writes to them change nothing.
- R10: When the counter is all ones and a tick arrives, the counter wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 15 | Byte offset within the window; bits 1:0 are ignored |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| timer_irq | output | NUM_HARTS | Timer interrupt, one line per hart |

## Verification
The assertions take a few things for granted about the inputs:
- The access inputs are stable and known at each clock edge.
- A single request is either a read or a write, never both.
- NUM_HARTS does not exceed 4095, so a compare slot never overlaps the counter slot.

The stimulus drives every input on the falling edge, one access per cycle, and only ever uses NUM_HARTS of 2. Word offsets are kept word-aligned, except where the test shows that the low address bits have no effect. The unmapped offsets used are an unimplemented hart slot and a point in the middle of the window.

// File: rtl/mtimer_unit.sv
module mtimer_unit #(
  parameter int NUM_HARTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [14:0]          bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam logic [11:0] CNT_SLOT = 12'hFFF;

  logic [63:0]                 mtime_q;
  logic [NUM_HARTS-1:0][63:0]  cmp_q;
  logic [11:0]                 slot;
  logic                        hi_sel, is_cnt, is_cmp, wr;
  logic [31:0]                 rd_val;

  assign slot   = bus_addr[14:3];
  assign hi_sel = bus_addr[2];
  assign is_cnt = slot == CNT_SLOT;
  assign is_cmp = !is_cnt && (int'(slot) < NUM_HARTS);
  assign wr     = bus_req && bus_we;

  function automatic logic [31:0] merge(input logic [31:0] old_w,
                                        input logic [31:0] new_w,
                                        input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)
      mtime_q <= '0;
    else if (wr && is_cnt) begin
      if (hi_sel) mtime_q[63:32] <= merge(mtime_q[63:32], bus_wdata, bus_be);
      else        mtime_q[31:0]  <= merge(mtime_q[31:0],  bus_wdata, bus_be);
    end else if (tick_en)
      mtime_q <= mtime_q + 64'd1;
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel;
    assign sel = is_cmp && (int'(slot) == h);

    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_q[h] <= '1;
      else if (wr && sel) begin
        if (hi_sel) cmp_q[h][63:32] <= merge(cmp_q[h][63:32], bus_wdata, bus_be);
        else        cmp_q[h][31:0]  <= merge(cmp_q[h][31:0],  bus_wdata, bus_be);
      end
    end

    assign timer_irq[h] = mtime_q >= cmp_q[h];
  end

  always_comb begin
    rd_val = '0;
    if (is_cnt)
      rd_val = hi_sel ? mtime_q[63:32] : mtime_q[31:0];
    else
      for (int h = 0; h < NUM_HARTS; h++)
        if (is_cmp && int'(slot) == h)
          rd_val = hi_sel ? cmp_q[h][63:32] : cmp_q[h][31:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (bus_req && !bus_we) ? rd_val : '0;
  end
endmodule

// File: rtl/mtimer_unit_chk.sv
module mtimer_unit_chk #(
  parameter int NUM_HARTS = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_en,
  input logic                        bus_req,
  input logic                        bus_we,
  input logic [14:0]                 bus_addr,
  input logic [31:0]                 bus_rdata,
  input logic [NUM_HARTS-1:0]        timer_irq,
  input logic [63:0]                 mtime,
  input logic [NUM_HARTS-1:0][63:0]  cmp
);
  logic cnt_wr, any_wr, rd_req, unmapped_rd, cnt_lo_rd;
  assign cnt_wr      = bus_req && bus_we && bus_addr[14:3] == 12'hFFF;
  assign any_wr      = bus_req && bus_we;
  assign rd_req      = bus_req && !bus_we;
  assign unmapped_rd = rd_req && bus_addr[14:3] != 12'hFFF && int'(bus_addr[14:3]) >= NUM_HARTS;
  assign cnt_lo_rd   = rd_req && bus_addr[14:2] == 13'h1FFE;

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !cnt_wr) |=> mtime == $past(mtime) + 64'd1);  // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr) |=> $stable(mtime));  // R2
  AST_CMP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(cmp));  // R9
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> bus_rdata == 32'd0);  // R9
  AST_NO_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> bus_rdata == 32'd0);  // R8
  AST_CNT_LO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_rd |=> bus_rdata == $past(mtime[31:0]));  // R3
  AST_IRQ_ONESHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_wr && !tick_en) |=> $stable(timer_irq));  // R7
endmodule

bind mtimer_unit mtimer_unit_chk #(.NUM_HARTS(NUM_HARTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .timer_irq(timer_irq), .mtime(mtime_q), .cmp(cmp_q));

// File: tb/mtimer_unit_tb.sv
`timescale 1ns/1ps
module mtimer_unit_tb_top;
  localparam int NH = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_req = 1'b0, bus_we = 1'b0;
  logic [14:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NH-1:0] timer_irq;

  always #2.5 clk = ~clk;

  mtimer_unit #(.NUM_HARTS(NH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq));

  int errors = 0, checks = 0;
  longint unsigned m_time;
  longint unsigned m_cmp[NH];
  logic [31:0] m_rd;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [14:0] a);
    int idx = int'(a[14:3]);
    if (idx == 4095) return a[2] ? m_time[63:32] : m_time[31:0];
    if (idx < NH)    return a[2] ? m_cmp[idx][63:32] : m_cmp[idx][31:0];
    return 32'd0;
  endfunction

  function automatic logic [63:0] m_put(input logic [63:0] v, input bit hi,
                                        input logic [3:0] be, input logic [31:0] d);
    logic [63:0] r = v;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[(hi ? 32 : 0) + 8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic step(input bit rq, input bit we, input logic [14:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input bit tk);
    int idx;
    bus_req = rq; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd; tick_en = tk;
    @(posedge clk);
    idx  = int'(a[14:3]);
    m_rd = (rq && !we) ? m_read(a) : 32'd0;
    if (rq && we && idx == 4095) m_time = m_put(m_time, a[2], be, wd);
    else if (tk)                 m_time = m_time + 1;
    if (rq && we && idx < NH)    m_cmp[idx] = m_put(m_cmp[idx], a[2], be, wd);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
    chk("R8 rdata", {32'd0, bus_rdata}, {32'd0, m_rd});
    for (int h = 0; h < NH; h++)
      chk("R7 irq", {63'd0, timer_irq[h]}, {63'd0, m_time >= m_cmp[h]});
  endtask

  task automatic rd(input logic [14:0] a, output logic [31:0] d);
    step(1'b1, 1'b0, a, 4'h0, 32'd0, 1'b0);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [14:0] a, input logic [3:0] be, input logic [31:0] d);
    step(1'b1, 1'b1, a, be, d, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_time = 0;
    for (int h = 0; h < NH; h++) m_cmp[h] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rdata", {32'd0, bus_rdata}, 64'd0);
    chk("R1 irq", {62'd0, timer_irq}, 64'd0);
    rd(15'h7FF8, d); chk("R1 counter lo", {32'd0, d}, 64'd0);
    rd(15'h0004, d); chk("R1 cmp0 hi", {32'd0, d}, 64'hFFFFFFFF);
    // R2 ticking
    repeat (5) step(1'b0, 1'b0, '0, '0, '0, 1'b1);
    step(1'b0, 1'b0, '0, '0, '0, 1'b0);
    rd(15'h7FF8, d); chk("R2 five ticks", {32'd0, d}, 64'd5);
    // R3 counter words
    wr(15'h7FFC, 4'hF, 32'h0000_0001);
    wr(15'h7FF8, 4'hF, 32'h0000_0010);
    rd(15'h7FFC, d); chk("R3 counter hi", {32'd0, d}, 64'h1);
    rd(15'h7FF8, d); chk("R3 counter lo", {32'd0, d}, 64'h10);
    // R4 compare words of hart 1
    wr(15'h0008, 4'hF, 32'hCAFE_0000);
    wr(15'h000C, 4'hF, 32'h0000_0002);
    rd(15'h0008, d); chk("R4 cmp1 lo", {32'd0, d}, 64'hCAFE_0000);
    rd(15'h000E, d); chk("R4 cmp1 hi low-bits ignored", {32'd0, d}, 64'h2);
    // R5 byte strobes
    wr(15'h0008, 4'b0010, 32'h1234_5678);
    rd(15'h0008, d); chk("R5 partial write", {32'd0, d}, 64'hCAFE_5600);
    // R6 write beats tick
    step(1'b1, 1'b1, 15'h7FF8, 4'hF, 32'h0000_0100, 1'b1);
    rd(15'h7FF8, d); chk("R6 write over tick", {32'd0, d}, 64'h100);
    rd(15'h7FFC, d); chk("R6 hi untouched", {32'd0, d}, 64'h1);
    // R7 interrupt crossing for hart 0
    wr(15'h0004, 4'hF, 32'h0000_0001);
    wr(15'h0000, 4'hF, 32'h0000_0103);
    chk("R7 irq0 below", {63'd0, timer_irq[0]}, 64'd0);
    repeat (3) step(1'b0, 1'b0, '0, '0, '0, 1'b1);
    chk("R7 irq0 reached", {63'd0, timer_irq[0]}, 64'd1);
    wr(15'h0000, 4'hF, 32'h0000_0FFF);
    chk("R7 irq0 cleared", {63'd0, timer_irq[0]}, 64'd0);
    // R9 unimplemented hart and unmapped offset
    wr(15'h0010, 4'hF, 32'hDEAD_BEEF);
    rd(15'h0010, d); chk("R9 hart2 slot", {32'd0, d}, 64'd0);
    rd(15'h4000, d); chk("R9 mid window", {32'd0, d}, 64'd0);
    rd(15'h0000, d); chk("R9 cmp0 intact", {32'd0, d}, 64'h0FFF);
    // R10 wrap
    wr(15'h7FFC, 4'hF, 32'hFFFF_FFFF);
    wr(15'h7FF8, 4'hF, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, '0, '0, '0, 1'b1);
    rd(15'h7FF8, d); chk("R10 wrap lo", {32'd0, d}, 64'd0);
    rd(15'h7FFC, d); chk("R10 wrap hi", {32'd0, d}, 64'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule